// File: doc/BRIEF.md
# Bit-Plane Lookup FIR Filter

This block is an eight-tap finite impulse response filter for unsigned 4-bit samples that contains no multipliers. Every accepted sample enters a window made of the sample itself and the seven samples accepted before it. Bit b of each of the eight window samples is taken, and together those bits form an 8-bit address into a table. Entry a of that table holds the sum of the coefficients whose tap index is set in a. The table contents are computed from a coefficient parameter when the design is elaborated. Four copies of the table serve the four bit planes in the same cycle. The four partial sums are then weighted by 1, 2, 4 and 8 and added, which gives one filtered value for each accepted sample.

A producer drives a sample with a one-cycle valid strobe, at any rate up to one sample per clock. The result appears two clock edges later with its own strobe. The block has no state machine. Its control is the valid bit as it passes through two register stages, named ACCEPT (the window is looked up and the four partial sums are registered) and EMIT (the weighted total is registered). An asserted valid moves a sample from ACCEPT to EMIT on the next edge. When valid is low, neither stage changes its data.

Top module: `dafir_filter`

## Requirements
- R1: While `rst_n` is low and after it rises, `out_valid` is 0 and `out_data` is 0 until the first result is produced.
- R2: For an accepted sample x[n], the result is y[n] = sum over i = 0..7 of h[i]·x[n−i], where tap 0 is the sample itself. Coefficient h[i] is the unsigned 4-bit field at bits 4i+3..4i of parameter `COEFS`.
- R3: `out_valid` is high exactly in the cycle two rising edges after the edge that sampled `in_valid` high, once for each accepted sample. Back-to-back samples give back-to-back results.
- R4: A cycle with `in_valid` low leaves the sample history unchanged, whatever value `in_sample` holds. Later results are the same as if that cycle had not occurred.
- R5: Reset clears the history to zero, so the first seven results after reset are computed as if all earlier samples were 0.
- R6: A single sample of 1 followed by zeros produces results equal to h[0], h[1], …, h[7] in that order.
- R7: A full-scale input (all samples 15) produces 15·Σh. The 12-bit output never exceeds 8·15·15.
- R8: `out_data` holds its last value in every cycle in which `out_valid` is low.
- R9: A reset in the middle of a stream discards both the history and any result still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe; `in_sample` is accepted on this edge |
| in_sample | input | 4 | Unsigned input sample |
| out_valid | output | 1 | Result strobe |
| out_data | output | 12 | Unsigned filtered result |

## Verification
A wrong entry in the history appears in the result at most two edges after the next accepted sample, and it stays visible for up to eight results until it leaves the window. For that reason every result in every stream is compared with a direct convolution. A wrong table entry or a wrong plane weight shows up only for the sample patterns that select that entry or plane. The impulse and full-scale streams reach every single-tap entry and the all-ones entry. A pseudo-random stream covers the mixed addresses. A stuck or misrouted valid bit shows up as a missing or misplaced strobe exactly two cycles after the sample that should have caused it.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    localparam int DEF_TAPS     = 8;
    localparam int DEF_SAMPLE_W = 4;
    localparam int DEF_COEF_W   = 4;

    // width of one bit-plane partial sum: a coefficient plus tap-count growth
    function automatic int plane_sum_width(input int taps, input int coef_w);
        return coef_w + $clog2(taps);
    endfunction

    // result width: sample bits + coefficient bits + tap growth + one guard bit
    function automatic int result_width(input int taps, input int sample_w, input int coef_w);
        return sample_w + coef_w + $clog2(taps) + 1;
    endfunction

endpackage

// File: rtl/dafir_history.sv
module dafir_history #(
    parameter int TAPS     = 8,
    parameter int SAMPLE_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic [SAMPLE_W-1:0]        din,
    output logic [TAPS*SAMPLE_W-1:0]   window
);

    localparam int STORED = TAPS - 1;

    logic [SAMPLE_W-1:0] stage_q [STORED];

    // tap 0 is the live sample
    assign window[SAMPLE_W-1:0] = din;

    generate
        for (genvar k = 0; k < STORED; k++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[k] <= '0;
                end else if (shift_en) begin
                    if (k == 0) stage_q[k] <= din;
                    else        stage_q[k] <= stage_q[k-1];
                end
            end
            assign window[(k+1)*SAMPLE_W +: SAMPLE_W] = stage_q[k];
        end
    endgenerate

    // R4: a history stage changes only on an accepted sample
    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(window[TAPS*SAMPLE_W-1:SAMPLE_W]));

    // R2: the newest stored sample is the one accepted on the previous edge
    assert_newest_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (window[2*SAMPLE_W-1:SAMPLE_W] == $past(din)));

endmodule

// File: rtl/dafir_plane_rom.sv
module dafir_plane_rom #(
    parameter int                          TAPS   = 8,
    parameter int                          COEF_W = 4,
    parameter logic [TAPS*COEF_W-1:0]      COEFS  = '0,
    localparam int                         PW     = COEF_W + $clog2(TAPS)
) (
    input  logic [TAPS-1:0] addr,
    output logic [PW-1:0]   sum
);

    localparam int DEPTH = 1 << TAPS;

    function automatic logic [DEPTH*PW-1:0] build_rom();
        logic [DEPTH*PW-1:0] rom;
        rom = '0;
        for (int a = 0; a < DEPTH; a++) begin
            logic [PW-1:0] acc;
            acc = '0;
            for (int i = 0; i < TAPS; i++) begin
                if (((a >> i) & 1) == 1)
                    acc = acc + PW'(COEFS[i*COEF_W +: COEF_W]);
            end
            rom[a*PW +: PW] = acc;
        end
        return rom;
    endfunction

    localparam logic [DEPTH*PW-1:0] ROM = build_rom();

    function automatic int coef_total();
        int t;
        t = 0;
        for (int i = 0; i < TAPS; i++) t += int'(COEFS[i*COEF_W +: COEF_W]);
        return t;
    endfunction

    localparam int MAX_SUM = coef_total();

    assign sum = ROM[int'(addr)*PW +: PW];

    // R2: an empty address selects no coefficient, and no entry exceeds the full sum
    always_comb begin
        if (addr == '0) assert_zero_entry_R2: assert (sum == '0);
        assert_entry_bound_R7: assert (int'(sum) <= MAX_SUM);
    end

endmodule

// File: rtl/dafir_combine.sv
module dafir_combine #(
    parameter int PLANES = 4,
    parameter int PW     = 7,
    parameter int OUT_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [PLANES*PW-1:0]  partials,
    output logic                  out_valid,
    output logic [OUT_W-1:0]      out_data
);

    // stage ACCEPT: registered bit-plane partial sums
    logic                 accept_v;
    logic [PLANES*PW-1:0] accept_q;
    logic [OUT_W-1:0]     weighted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_v <= 1'b0;
            accept_q <= '0;
        end else begin
            accept_v <= in_valid;
            if (in_valid) accept_q <= partials;
        end
    end

    always_comb begin
        weighted = '0;
        for (int b = 0; b < PLANES; b++)
            weighted = weighted + (OUT_W'(accept_q[b*PW +: PW]) << b);
    end

    // stage EMIT: registered result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= accept_v;
            if (accept_v) out_data <= weighted;
        end
    end

    // R8: the result word only moves together with its strobe
    assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

// File: rtl/dafir_filter.sv
module dafir_filter
    import dafir_pkg::*;
#(
    parameter int                          TAPS     = DEF_TAPS,
    parameter int                          SAMPLE_W = DEF_SAMPLE_W,
    parameter int                          COEF_W   = DEF_COEF_W,
    parameter logic [TAPS*COEF_W-1:0]      COEFS    = 32'h6295_1413,
    localparam int                         OUT_W    = result_width(TAPS, SAMPLE_W, COEF_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SAMPLE_W-1:0]  in_sample,
    output logic                 out_valid,
    output logic [OUT_W-1:0]     out_data
);

    localparam int PW      = plane_sum_width(TAPS, COEF_W);
    localparam int PLANES  = SAMPLE_W;
    localparam int MAX_OUT = TAPS * ((1 << SAMPLE_W) - 1) * ((1 << COEF_W) - 1);

    logic [TAPS*SAMPLE_W-1:0] window;
    logic [PLANES*PW-1:0]     partials;

    dafir_history #(.TAPS(TAPS), .SAMPLE_W(SAMPLE_W)) i_history (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (in_sample),
        .window   (window)
    );

    generate
        for (genvar b = 0; b < PLANES; b++) begin : g_plane
            logic [TAPS-1:0] addr;
            for (genvar i = 0; i < TAPS; i++) begin : g_bit
                assign addr[i] = window[i*SAMPLE_W + b];
            end
            dafir_plane_rom #(.TAPS(TAPS), .COEF_W(COEF_W), .COEFS(COEFS)) i_rom (
                .addr (addr),
                .sum  (partials[b*PW +: PW])
            );
        end
    endgenerate

    dafir_combine #(.PLANES(PLANES), .PW(PW), .OUT_W(OUT_W)) i_combine (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .partials  (partials),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R3: every accepted sample yields a strobe two edges later
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R3: no strobe appears without a sample two edges earlier
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R7: the result stays inside the full-scale bound
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(out_data) <= MAX_OUT);

endmodule

// File: tb/test_dafir_filter.sv
module test_dafir_filter;

    localparam int TAPS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_sample = '0;
    logic        out_valid;
    logic [11:0] out_data;

    int h [TAPS] = '{3, 1, 4, 1, 5, 9, 2, 6};

    int checks = 0;
    int errors = 0;

    // reference model state
    int hist [TAPS];
    bit slot_v [2];
    int slot_d [2];
    int last_d;
    logic [15:0] lfsr = 16'hACE1;

    dafir_filter #(.COEFS(32'h6295_1413)) i_dafir_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int convolve();
        int s;
        s = 0;
        for (int i = 0; i < TAPS; i++) s += h[i] * hist[i];
        return s;
    endfunction

    // one cycle: check the result due now, then drive the next input
    task automatic step(input string req, input bit v, input int sample);
        @(negedge clk);
        check({req, " strobe"}, int'(out_valid), int'(slot_v[0]));
        check({req, " data"}, int'(out_data), slot_d[0]);
        slot_v[0] = slot_v[1];
        slot_d[0] = slot_d[1];
        if (v) begin
            for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = sample;
            last_d = convolve();
        end
        slot_v[1] = v;
        slot_d[1] = last_d;
        in_valid  = v;
        in_sample = 4'(sample);
    endtask

    task automatic drain(input string req);
        step(req, 1'b0, 0);
        step(req, 1'b0, 0);
        step(req, 1'b0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 strobe in reset", int'(out_valid), 0);
        check("R1 data in reset", int'(out_data), 0);
        rst_n = 1'b1;
        for (int i = 0; i < TAPS; i++) hist[i] = 0;
        slot_v = '{0, 0};
        slot_d = '{0, 0};
        last_d = 0;
        @(negedge clk);
        check("R1 strobe after reset", int'(out_valid), 0);
        check("R1 data after reset", int'(out_data), 0);
    endtask

    // R6: impulse reads back the coefficients in tap order (R5: zero history)
    task automatic t_impulse();
        do_reset();
        step("R6 impulse", 1'b1, 1);
        for (int i = 1; i < TAPS + 2; i++) step("R6 R5 impulse tail", 1'b1, 0);
        drain("R6 drain");
    endtask

    // R7: full-scale input
    task automatic t_fullscale();
        do_reset();
        for (int i = 0; i < TAPS + 4; i++) step("R7 full scale", 1'b1, 15);
        drain("R7 drain");
        check("R7 full scale value", int'(out_data), 15 * 31);
    endtask

    // R2: pseudo-random back-to-back stream
    task automatic t_stream();
        do_reset();
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R2 R3 stream", 1'b1, int'(lfsr[3:0]));
        end
        drain("R2 drain");
    endtask

    // R4 R8: idle cycles with garbage on the sample input
    task automatic t_gaps();
        do_reset();
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R4 R8 gaps", lfsr[7] | lfsr[5], int'(lfsr[3:0]));
        end
        drain("R4 drain");
    endtask

    // R9: reset with results in flight
    task automatic t_midreset();
        do_reset();
        for (int i = 0; i < 5; i++) step("R9 prefill", 1'b1, 9 + i);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < TAPS; i++) hist[i] = 0;
        slot_v = '{0, 0};
        slot_d = '{0, 0};
        last_d = 0;
        step("R9 after reset", 1'b0, 0);
        step("R9 flush", 1'b1, 2);
        step("R9 flush", 1'b1, 0);
        drain("R9 drain");
        check("R9 history cleared", int'(out_data), 2 * h[1]);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_impulse();
        t_fullscale();
        t_stream();
        t_gaps();
        t_midreset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule